// File: doc/BRIEF.md
# Split-Permission Direct-Mapped Translation Cache

This block caches virtual-to-physical page translations in a direct-mapped array indexed by the low bits of the virtual page number. Every entry holds one physical page number that all access types share, and three independent tags, one each for instruction fetch, data load and data store. An entry can therefore answer a load while it misses for a fetch of the same page. The enclosing pipeline performs page-table walks and permission checks. It then installs results through the refill port, which grants hits only to the access type that caused the fill.

Lookups are combinational from the registered arrays. A refill updates the array on the clock edge. A flush input drops every tag in one cycle. Refill clears the tags of the indexed entry that hold another page. Tags that already hold the same page keep their validity, so a load fill after a fetch fill of one page leaves both types hitting.

Top module: `xlat_cache`

## Requirements
- R1: After reset, every lookup misses, whatever its address or access type.
- R2: The entry index is the virtual page number modulo ENTRIES (its low bits), and the tag is the full virtual page number. A lookup whose page shares an index with a cached page but differs from it misses.
- R3: Access type codes are 0 for fetch, 1 for load and 2 for store. A lookup hits only when the tag of its own type in the indexed entry is valid and equals the looked-up page number.
- R4: A refill invalidates every tag of the indexed entry, of any type, that does not already hold the refilled page number.
- R5: A refill makes only the tag of its own access type valid with the new page. Tags of other types that already held the same page stay valid.
- R6: The physical page number of an entry is overwritten by every refill. A type that still hits after another type's refill returns the new physical page.
- R7: On a hit, the physical address is the stored physical page number in the upper bits and the 12-bit page offset of the looked-up virtual address in the lower bits.
- R8: A flush invalidates all tags of all types in all entries in one cycle. Every lookup in the following cycle misses.
- R9: When flush and refill are asserted in the same cycle, the flush wins and the refill leaves no valid tag.
- R10: A lookup in the same cycle as a refill to its entry sees the contents from before the refill. The refill is visible from the next cycle.
- R11: Access type code 3 never hits on lookup, and a refill carrying code 3 changes no tag and no physical page number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset of all valid bits |
| flush_i | input | 1 | Invalidate every tag |
| lk_vaddr_i | input | VPN_W+OFFSET_W | Lookup virtual address |
| lk_kind_i | input | 2 | Lookup access type (0 fetch, 1 load, 2 store, 3 none) |
| lk_hit_o | output | 1 | Lookup hit |
| lk_paddr_o | output | PPN_W+OFFSET_W | Translated physical address, meaningful on hit |
| fill_en_i | input | 1 | Refill strobe |
| fill_vpn_i | input | VPN_W | Virtual page number being installed |
| fill_ppn_i | input | PPN_W | Physical page number being installed |
| fill_kind_i | input | 2 | Access type that caused the refill |

## Verification
The bench builds the block with four entries, 10-bit virtual and 8-bit physical page numbers. With so few entries, pages 5 and 9 alias on one index, so tag replacement by a foreign page (R2, R4) happens after only a couple of fills. Narrow page numbers let a swept pseudo-random sequence revisit every index and access type many times. A shadow model in the bench covers the shared physical field, mixed-type retention and the flush-versus-refill priority.

// File: rtl/xlat_cache_pkg.sv
package xlat_cache_pkg;

   typedef enum logic [1:0] {
      ACC_FETCH = 2'd0,
      ACC_LOAD  = 2'd1,
      ACC_STORE = 2'd2,
      ACC_NONE  = 2'd3
   } acc_kind_e;

   localparam int unsigned NUM_KINDS = 3;

   function automatic logic kind_is_real(input logic [1:0] k);
      return k != ACC_NONE;
   endfunction

endpackage

// File: rtl/xlat_tag_bank.sv
module xlat_tag_bank #(
   parameter int unsigned ENTRIES = 16,
   parameter int unsigned VPN_W   = 20,
   localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush_i,
   input  logic             fill_en_i,
   input  logic             fill_grant_i,
   input  logic [VPN_W-1:0] fill_vpn_i,
   input  logic [VPN_W-1:0] lk_vpn_i,
   output logic             lk_match_o
);

   logic [ENTRIES-1:0] valid_q;
   logic [VPN_W-1:0]   tag_q [ENTRIES];
   logic [IDX_W-1:0]   fill_idx;
   logic [IDX_W-1:0]   lk_idx;
   logic               same_page;

   assign fill_idx  = fill_vpn_i[IDX_W-1:0];
   assign lk_idx    = lk_vpn_i[IDX_W-1:0];
   assign same_page = valid_q[fill_idx] && (tag_q[fill_idx] == fill_vpn_i);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= '0;
      end else if (flush_i) begin
         valid_q <= '0;
      end else if (fill_en_i) begin
         if (fill_grant_i) begin
            valid_q[fill_idx] <= 1'b1;
         end else if (!same_page) begin
            valid_q[fill_idx] <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!flush_i && fill_en_i && fill_grant_i) begin
         tag_q[fill_idx] <= fill_vpn_i;
      end
   end

   assign lk_match_o = valid_q[lk_idx] && (tag_q[lk_idx] == lk_vpn_i);

   // R8
   flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |=> !lk_match_o);

   // R5
   grant_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_en_i && fill_grant_i && !flush_i) |=>
         (valid_q[$past(fill_idx)] && (tag_q[$past(fill_idx)] == $past(fill_vpn_i))));

   // R4
   stale_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_en_i && !fill_grant_i && !flush_i && !same_page) |=> !valid_q[$past(fill_idx)]);

   // R5
   same_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_en_i && !fill_grant_i && !flush_i && same_page) |=> valid_q[$past(fill_idx)]);

endmodule

// File: rtl/xlat_ppn_store.sv
module xlat_ppn_store #(
   parameter int unsigned ENTRIES = 16,
   parameter int unsigned PPN_W   = 20,
   localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en_i,
   input  logic [IDX_W-1:0] wr_idx_i,
   input  logic [PPN_W-1:0] wr_ppn_i,
   input  logic [IDX_W-1:0] rd_idx_i,
   output logic [PPN_W-1:0] rd_ppn_o
);

   logic [PPN_W-1:0] ppn_q [ENTRIES];

   always_ff @(posedge clk) begin
      if (wr_en_i) begin
         ppn_q[wr_idx_i] <= wr_ppn_i;
      end
   end

   assign rd_ppn_o = ppn_q[rd_idx_i];

   // R6
   ppn_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_i |=> (ppn_q[$past(wr_idx_i)] == $past(wr_ppn_i)));

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
   import xlat_cache_pkg::*;
#(
   parameter int unsigned ENTRIES  = 16,
   parameter int unsigned VPN_W    = 20,
   parameter int unsigned PPN_W    = 20,
   parameter int unsigned OFFSET_W = 12,
   localparam int unsigned IDX_W   = $clog2(ENTRIES),
   localparam int unsigned VA_W    = VPN_W + OFFSET_W,
   localparam int unsigned PA_W    = PPN_W + OFFSET_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush_i,
   input  logic [VA_W-1:0]  lk_vaddr_i,
   input  logic [1:0]       lk_kind_i,
   output logic             lk_hit_o,
   output logic [PA_W-1:0]  lk_paddr_o,
   input  logic             fill_en_i,
   input  logic [VPN_W-1:0] fill_vpn_i,
   input  logic [PPN_W-1:0] fill_ppn_i,
   input  logic [1:0]       fill_kind_i
);

   if (ENTRIES < 2 || (ENTRIES & (ENTRIES - 1)) != 0) begin : g_bad_entries
      $error("xlat_cache: ENTRIES must be a power of two of at least 2");
   end
   if (VPN_W < IDX_W) begin : g_bad_vpn
      $error("xlat_cache: VPN_W must cover the index bits");
   end
   if (PPN_W < 1 || OFFSET_W < 1) begin : g_bad_widths
      $error("xlat_cache: PPN_W and OFFSET_W must be positive");
   end

   logic [VPN_W-1:0]     lk_vpn;
   logic [OFFSET_W-1:0]  lk_off;
   logic                 fill_live;
   logic [NUM_KINDS-1:0] bank_match;
   logic [PPN_W-1:0]     lk_ppn;

   assign lk_vpn    = lk_vaddr_i[VA_W-1:OFFSET_W];
   assign lk_off    = lk_vaddr_i[OFFSET_W-1:0];
   assign fill_live = fill_en_i && kind_is_real(fill_kind_i);

   for (genvar k = 0; k < NUM_KINDS; k++) begin : g_bank
      xlat_tag_bank #(
         .ENTRIES (ENTRIES),
         .VPN_W   (VPN_W)
      ) u_bank (
         .clk          (clk),
         .rst_n        (rst_n),
         .flush_i      (flush_i),
         .fill_en_i    (fill_live),
         .fill_grant_i (fill_kind_i == 2'(k)),
         .fill_vpn_i   (fill_vpn_i),
         .lk_vpn_i     (lk_vpn),
         .lk_match_o   (bank_match[k])
      );
   end

   xlat_ppn_store #(
      .ENTRIES (ENTRIES),
      .PPN_W   (PPN_W)
   ) u_ppn (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en_i  (fill_live && !flush_i),
      .wr_idx_i (fill_vpn_i[IDX_W-1:0]),
      .wr_ppn_i (fill_ppn_i),
      .rd_idx_i (lk_vpn[IDX_W-1:0]),
      .rd_ppn_o (lk_ppn)
   );

   always_comb begin
      unique case (acc_kind_e'(lk_kind_i))
         ACC_FETCH: lk_hit_o = bank_match[0];
         ACC_LOAD:  lk_hit_o = bank_match[1];
         ACC_STORE: lk_hit_o = bank_match[2];
         default:   lk_hit_o = 1'b0;
      endcase
   end

   assign lk_paddr_o = {lk_ppn, lk_off};

   // R11
   none_kind_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_kind_i == 2'd3) |-> !lk_hit_o);

   // R9
   flush_beats_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_i && fill_en_i) |=> (bank_match == '0));

endmodule

// File: tb/xlat_cache_bench.sv
module xlat_cache_bench;

   localparam int unsigned E    = 4;
   localparam int unsigned VW   = 10;
   localparam int unsigned PW   = 8;
   localparam int unsigned OW   = 12;
   localparam int unsigned IW   = $clog2(E);
   localparam int unsigned VA_W = VW + OW;
   localparam int unsigned PA_W = PW + OW;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            flush_i = 1'b0;
   logic [VA_W-1:0] lk_vaddr_i = '0;
   logic [1:0]      lk_kind_i = '0;
   logic            lk_hit_o;
   logic [PA_W-1:0] lk_paddr_o;
   logic            fill_en_i = 1'b0;
   logic [VW-1:0]   fill_vpn_i = '0;
   logic [PW-1:0]   fill_ppn_i = '0;
   logic [1:0]      fill_kind_i = '0;

   always #10 clk = ~clk;

   xlat_cache #(.ENTRIES(E), .VPN_W(VW), .PPN_W(PW), .OFFSET_W(OW)) u_xlat_cache (
      .clk(clk), .rst_n(rst_n), .flush_i(flush_i),
      .lk_vaddr_i(lk_vaddr_i), .lk_kind_i(lk_kind_i),
      .lk_hit_o(lk_hit_o), .lk_paddr_o(lk_paddr_o),
      .fill_en_i(fill_en_i), .fill_vpn_i(fill_vpn_i),
      .fill_ppn_i(fill_ppn_i), .fill_kind_i(fill_kind_i)
   );

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   typedef struct packed {
      logic            hit;
      logic [PA_W-1:0] paddr;
   } exp_t;

   exp_t  exp_q [$];
   string req_q [$];

   logic          mval [3][E];
   logic [VW-1:0] mtag [3][E];
   logic [PW-1:0] mppn [E];

   task automatic step(input bit fe, input int fvpn, input int fppn, input int fkind,
                       input bit fl, input bit ld, input int lvpn, input int loff,
                       input int lkind, input string req);
      exp_t e;
      logic [VW-1:0] lv;
      logic [IW-1:0] li;
      logic [VW-1:0] fv;
      logic [IW-1:0] fi;
      @(negedge clk);
      lv = VW'(lvpn);
      li = lv[IW-1:0];
      fv = VW'(fvpn);
      fi = fv[IW-1:0];
      fill_en_i   = fe;
      fill_vpn_i  = fv;
      fill_ppn_i  = PW'(fppn);
      fill_kind_i = 2'(fkind);
      flush_i     = fl;
      lk_vaddr_i  = {lv, OW'(loff)};
      lk_kind_i   = 2'(lkind);
      if (ld) begin
         e.hit   = (lkind < 3) && mval[lkind][li] && (mtag[lkind][li] == lv);
         e.paddr = {mppn[li], OW'(loff)};
         exp_q.push_back(e);
         req_q.push_back(req);
      end
      @(posedge clk);
      if (fl) begin
         for (int k = 0; k < 3; k++)
            for (int i = 0; i < E; i++) mval[k][i] = 1'b0;
      end else if (fe && fkind < 3) begin
         for (int k = 0; k < 3; k++) begin
            if (k == fkind) begin
               mval[k][fi] = 1'b1;
               mtag[k][fi] = fv;
            end else if (!(mval[k][fi] && mtag[k][fi] == fv)) begin
               mval[k][fi] = 1'b0;
            end
         end
         mppn[fi] = PW'(fppn);
      end
   endtask

   task automatic look(input int vpn, input int off, input int kind, input string req);
      step(1'b0, 0, 0, 0, 1'b0, 1'b1, vpn, off, kind, req);
   endtask

   task automatic fill(input int vpn, input int ppn, input int kind);
      step(1'b1, vpn, ppn, kind, 1'b0, 1'b0, 0, 0, 0, "");
   endtask

   // monitor: compares just before the rising edge
   initial begin
      forever begin
         @(negedge clk);
         #5;
         while (exp_q.size() > 0) begin
            exp_t e;
            string r;
            e = exp_q.pop_front();
            r = req_q.pop_front();
            total++;
            if (lk_hit_o !== e.hit) begin
               bad++;
               $display("FAIL %s hit: actual=%0b expected=%0b", r, lk_hit_o, e.hit);
            end else if (e.hit && lk_paddr_o !== e.paddr) begin
               bad++;
               $display("FAIL %s paddr: actual=%h expected=%h", r, lk_paddr_o, e.paddr);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         bad++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int seed;
      for (int k = 0; k < 3; k++)
         for (int i = 0; i < E; i++) begin
            mval[k][i] = 1'b0;
            mtag[k][i] = '0;
         end
      for (int i = 0; i < E; i++) mppn[i] = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: empty after reset
      for (int k = 0; k < 4; k++) look(5, 12'h010, k, "R1");
      look(0, 0, 1, "R1");

      // R3 / R7: load fill answers loads only
      fill(5, 8'h3A, 1);
      look(5, 12'hABC, 1, "R7");
      look(5, 12'h001, 0, "R3");
      look(5, 12'h001, 2, "R3");

      // R5 / R6: fetch fill of same page keeps load, shares new ppn
      fill(5, 8'h3B, 0);
      look(5, 12'h123, 1, "R6");
      look(5, 12'hFFF, 0, "R5");
      look(5, 12'h000, 2, "R5");

      // R2: aliasing page on same index
      look(9, 12'h123, 1, "R2");
      look(9, 12'h123, 0, "R2");

      // R4: foreign page store fill evicts fetch and load
      fill(9, 8'h11, 2);
      look(5, 12'h040, 1, "R4");
      look(5, 12'h040, 0, "R4");
      look(9, 12'h040, 2, "R4");
      look(9, 12'h040, 1, "R4");

      // R10: refill and lookup in one cycle
      step(1'b1, 9, 8'h22, 1, 1'b0, 1'b1, 9, 12'h777, 1, "R10");
      look(9, 12'h777, 1, "R10");
      look(9, 12'h778, 2, "R10");

      // R11: reserved type code
      look(9, 12'h100, 3, "R11");
      fill(9, 8'h55, 3);
      look(9, 12'h100, 1, "R11");
      look(9, 12'h100, 2, "R11");
      look(9, 12'h100, 0, "R11");

      // other indices
      fill(2, 8'h80, 0);
      fill(7, 8'h81, 1);
      fill(12, 8'h82, 2);
      look(2, 12'h002, 0, "R3");
      look(7, 12'h007, 1, "R3");
      look(12, 12'h00C, 2, "R3");

      // R8: flush empties all
      step(1'b0, 0, 0, 0, 1'b1, 1'b0, 0, 0, 0, "");
      look(2, 12'h002, 0, "R8");
      look(7, 12'h007, 1, "R8");
      look(12, 12'h00C, 2, "R8");
      look(9, 12'h100, 1, "R8");

      // R9: flush beats simultaneous refill
      step(1'b1, 6, 8'h44, 1, 1'b1, 1'b0, 0, 0, 0, "");
      look(6, 12'h006, 1, "R9");

      // R3 sweep with aliasing pages and mixed types
      seed = 32'h1d3;
      for (int n = 0; n < 300; n++) begin
         int v;
         int p;
         int kf;
         int kl;
         seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
         v  = (seed >> 4) % 12;
         p  = (seed >> 9) & 8'hFF;
         kf = (seed >> 17) % 4;
         kl = (seed >> 21) % 4;
         step((seed & 3) != 0, v, p, kf, (seed % 97) == 0, 1'b1,
              (seed >> 11) % 12, seed & 12'hFFF, kl, "R3");
      end
      look(0, 0, 0, "R3");

      repeat (2) @(posedge clk);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule